// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset and supply-supervision request of a chip into one system reset and keeps a record of which request acted last. The inputs are a power-on request and an active-low external reset pin. A watchdog counter resets the chip when firmware fails to kick it. A software reset fires on a keyed write. Three supply-monitor flags, analog-low, digital-low and analog-high, arrive already synchronous from their comparators.

Each request reaches the system reset through a stretcher, so every reset lasts at least a parameterised number of clock cycles. The two low-voltage flags are each routed to either an interrupt or a reset by a configuration input. The analog-high flag always raises an interrupt. A one-hot cause register records the most recent event. It survives every reset except power-on, and firmware clears it by writing ones.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_req` is high, `sys_rst` is high, `status` reads 0x01 (bit 0 = power-on) and `irq` is low. A later power-on clears any earlier cause.
- R2: `sys_rst` rises on the clock edge that first samples any reset request. It stays high for exactly MIN_W (default 8) cycles after the last edge at which a request was sampled active, so a held request lengthens it.
- R3: `ext_rst_n` passes through a two-flop synchronizer and a filter that needs FILT_LEN (default 4) consecutive equal samples. A low level held long enough raises `sys_rst` 7 cycles after the pin falls and sets status bit 1. A low pulse of 3 cycles changes neither `sys_rst` nor `status`.
- R4: With `wdt_en` high and `sleep_mode` low, the watchdog counter advances once per cycle from 0, starting at the last kick. If it reaches `wdt_period` unkicked, `sys_rst` rises `wdt_period`+1 cycles after the kick edge and status bit 2 is set.
- R5: A `wdt_kick` strobe clears the watchdog counter, so kicking more often than the period never resets. While `sleep_mode` is high the watchdog is held cleared and never resets.
- R6: A write (`ctl_wr`) of the key 0xA5 on `ctl_wdata` causes a reset and sets status bit 3. A write of any other value changes neither `sys_rst` nor `status`.
- R7: A rising analog-low flag (status bit 4) or digital-low flag (status bit 5) sets its status bit. With its route input (`alo_to_rst`, `dlo_to_rst`) low, it raises `irq` and causes no reset. With the route input high, it holds `sys_rst` while the flag is high and does not raise `irq`.
- R8: A rising analog-high flag sets status bit 6 and raises `irq`, and it never causes a reset, whatever the route inputs say.
- R9: `status` is one-hot or zero. Each new event (the rising edge of a request) replaces it on the cycle the event is sampled. When events start together, the lowest bit index wins. A system reset other than power-on leaves `status` unchanged.
- R10: A `clr_wr` write clears the `status` bits set in `clr_mask` and drops the matching pending interrupts (`clr_mask` bits 4 to 6). Bits outside the mask keep their value. An event sampled in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, active high; also the block's own synchronous reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_en | input | 1 | Watchdog enable |
| sleep_mode | input | 1 | Chip in a sleep or hibernate state; holds the watchdog inactive |
| wdt_kick | input | 1 | Watchdog service strobe |
| wdt_period | input | WDT_W (16) | Watchdog timeout in cycles |
| ctl_wr | input | 1 | Software reset control write strobe |
| ctl_wdata | input | KEY_W (8) | Software reset control write data |
| mon_alo | input | 1 | Analog low-voltage flag |
| mon_dlo | input | 1 | Digital low-voltage flag |
| mon_ahi | input | 1 | Analog high-voltage flag |
| alo_to_rst | input | 1 | Route the analog-low flag to reset (1) or interrupt (0) |
| dlo_to_rst | input | 1 | Route the digital-low flag to reset (1) or interrupt (0) |
| clr_wr | input | 1 | Write-one-to-clear strobe for the cause register |
| clr_mask | input | 7 | Bits to clear |
| sys_rst | output | 1 | Stretched system reset, active high |
| irq | output | 1 | Supply-monitor interrupt pending |
| status | output | 7 | One-hot cause of the latest reset or monitor interrupt |

## Verification
The bench drives inputs on falling edges and counts rising edges to the cycle where each result is due. Keyed writes, monitor flags and clears show in `status` and `irq` one edge later. The watchdog resets `wdt_period`+1 edges after its last kick, and the external pin needs 7 edges because of two sync stages, four filter samples and the stretcher. Each check samples on the falling edge just before and just after the due edge. Reset width is counted in falling edges from the first high sample, so an off-by-one in the stretcher shows directly.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int NSRC = 7;

    // Cause bit positions; a lower index wins when events coincide.
    localparam int C_POR  = 0;
    localparam int C_XRES = 1;
    localparam int C_WDT  = 2;
    localparam int C_SW   = 3;
    localparam int C_ALO  = 4;
    localparam int C_DLO  = 5;
    localparam int C_AHI  = 6;

    typedef logic [NSRC-1:0] cause_vec_t;

    // Packed so that the bit order matches the cause positions above.
    typedef struct packed {
        logic ahi;
        logic dlo;
        logic alo;
        logic sw;
        logic wdt;
        logic xres;
        logic por;
    } src_t;

    // Keep only the lowest set bit.
    function automatic cause_vec_t pick_first(cause_vec_t v);
        cause_vec_t neg;
        neg = (~v) + cause_vec_t'(1);
        return v & neg;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic active
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] fcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            fcnt   <= '0;
            active <= 1'b0;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            if ((!s2) != active) begin
                if (fcnt == CW'(FILT_LEN - 1)) begin
                    active <= !s2;
                    fcnt   <= '0;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end else begin
                fcnt <= '0;
            end
        end
    end
endmodule

// File: rtl/rstc_watchdog.sv
module rstc_watchdog #(
    parameter int WDT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             kick,
    input  logic [WDT_W-1:0] period,
    output logic             bite
);
    logic [WDT_W-1:0] cnt;

    assign bite = !hold && !kick && (cnt == period);

    always_ff @(posedge clk) begin
        if (rst || hold || kick || bite) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int MIN_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic active
);
    localparam int CW = $clog2(MIN_W + 1);

    logic [CW-1:0] cnt;

    assign active = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || req) begin
            cnt <= CW'(MIN_W);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
    import rstc_pkg::*;
#(
    parameter int           MIN_W    = 8,
    parameter int           FILT_LEN = 4,
    parameter int           WDT_W    = 16,
    parameter int           KEY_W    = 8,
    parameter logic [KEY_W-1:0] SW_KEY = 8'hA5
) (
    input  logic             clk,
    input  logic             por_req,
    input  logic             ext_rst_n,
    input  logic             wdt_en,
    input  logic             sleep_mode,
    input  logic             wdt_kick,
    input  logic [WDT_W-1:0] wdt_period,
    input  logic             ctl_wr,
    input  logic [KEY_W-1:0] ctl_wdata,
    input  logic             mon_alo,
    input  logic             mon_dlo,
    input  logic             mon_ahi,
    input  logic             alo_to_rst,
    input  logic             dlo_to_rst,
    input  logic             clr_wr,
    input  logic [NSRC-1:0]  clr_mask,
    output logic             sys_rst,
    output logic             irq,
    output logic [NSRC-1:0]  status
);
    logic       xres_act;
    logic       wdt_bite;
    logic       sw_hit;
    logic       rst_req;
    src_t       src;
    cause_vec_t src_v, src_q, rise, win;
    logic [2:0] irq_pend, irq_new, irq_clr;

    rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
        .clk    (clk),
        .rst    (por_req),
        .pin_n  (ext_rst_n),
        .active (xres_act)
    );

    rstc_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk    (clk),
        .rst    (por_req),
        .hold   (sys_rst || !wdt_en || sleep_mode),
        .kick   (wdt_kick),
        .period (wdt_period),
        .bite   (wdt_bite)
    );

    assign sw_hit = ctl_wr && (ctl_wdata == SW_KEY);

    always_comb begin
        src.por  = por_req;
        src.xres = xres_act;
        src.wdt  = wdt_bite;
        src.sw   = sw_hit;
        src.alo  = mon_alo;
        src.dlo  = mon_dlo;
        src.ahi  = mon_ahi;
    end

    assign src_v = cause_vec_t'(src);
    assign rise  = src_v & ~src_q;
    assign win   = pick_first(rise);

    assign rst_req = por_req || xres_act || wdt_bite || sw_hit
                   || (mon_alo && alo_to_rst) || (mon_dlo && dlo_to_rst);

    rstc_stretch #(.MIN_W(MIN_W)) u_str (
        .clk    (clk),
        .rst    (por_req),
        .req    (rst_req),
        .active (sys_rst)
    );

    assign irq_new = {rise[C_AHI],
                      rise[C_DLO] && !dlo_to_rst,
                      rise[C_ALO] && !alo_to_rst};
    assign irq_clr = clr_wr ? clr_mask[C_AHI:C_ALO] : 3'b000;

    always_ff @(posedge clk) begin
        src_q <= src_v;
        if (por_req) begin
            status   <= cause_vec_t'(1) << C_POR;
            irq_pend <= '0;
        end else begin
            if (rise != '0) begin
                status <= win;
            end else if (clr_wr) begin
                status <= status & ~clr_mask;
            end
            irq_pend <= (irq_pend & ~irq_clr) | irq_new;
        end
    end

    assign irq = |irq_pend;
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk #(
    parameter int               MIN_W  = 8,
    parameter int               KEY_W  = 8,
    parameter logic [KEY_W-1:0] SW_KEY = 8'hA5
) (
    input logic             clk,
    input logic             por_req,
    input logic             ctl_wr,
    input logic [KEY_W-1:0] ctl_wdata,
    input logic             mon_alo,
    input logic             alo_to_rst,
    input logic             mon_ahi,
    input logic             sys_rst,
    input logic             irq,
    input logic [6:0]       status
);
    localparam int HW = $clog2(MIN_W + 1) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (por_req) begin
            hi_cnt <= '0;
        end else if (sys_rst) begin
            if (hi_cnt < HW'(MIN_W)) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    AST_POR_HOLD: assert property (@(posedge clk)
        por_req |=> (sys_rst && status == 7'h01 && !irq)); // R1

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> (hi_cnt >= HW'(MIN_W))); // R2

    AST_SW_KEY_RESET: assert property (@(posedge clk) disable iff (por_req)
        (ctl_wr && ctl_wdata == SW_KEY) |=> sys_rst); // R6

    AST_ALO_ROUTED_RESET: assert property (@(posedge clk) disable iff (por_req)
        (mon_alo && alo_to_rst) |=> sys_rst); // R7

    AST_AHI_IRQ: assert property (@(posedge clk) disable iff (por_req)
        $rose(mon_ahi) |=> irq); // R8

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (por_req)
        $onehot0(status)); // R9
endmodule

bind rst_ctrl rst_ctrl_chk #(.MIN_W(MIN_W), .KEY_W(KEY_W), .SW_KEY(SW_KEY)) u_chk (
    .clk        (clk),
    .por_req    (por_req),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .mon_alo    (mon_alo),
    .alo_to_rst (alo_to_rst),
    .mon_ahi    (mon_ahi),
    .sys_rst    (sys_rst),
    .irq        (irq),
    .status     (status)
);

// File: tb/rst_ctrl_bench.sv
module rst_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_W      = 8;
    localparam int WDT_P      = 20;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        por_req = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        wdt_en = 1'b0;
    logic        sleep_mode = 1'b0;
    logic        wdt_kick = 1'b0;
    logic [15:0] wdt_period = 16'(WDT_P);
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        mon_alo = 1'b0;
    logic        mon_dlo = 1'b0;
    logic        mon_ahi = 1'b0;
    logic        alo_to_rst = 1'b0;
    logic        dlo_to_rst = 1'b0;
    logic        clr_wr = 1'b0;
    logic [6:0]  clr_mask = 7'h00;
    logic        sys_rst;
    logic        irq;
    logic [6:0]  status;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rst_ctrl u_rst_ctrl (
        .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wdt_en(wdt_en),
        .sleep_mode(sleep_mode), .wdt_kick(wdt_kick), .wdt_period(wdt_period),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .mon_alo(mon_alo), .mon_dlo(mon_dlo),
        .mon_ahi(mon_ahi), .alo_to_rst(alo_to_rst), .dlo_to_rst(dlo_to_rst),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .sys_rst(sys_rst), .irq(irq),
        .status(status)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts falling edges with sys_rst high, starting now.
    task automatic measure_width(string req);
        int w = 0;
        while (sys_rst === 1'b1 && w < 100) begin
            w++;
            @(negedge clk);
        end
        check(req, "reset width", w, MIN_W);
    endtask

    task automatic clear_all();
        clr_wr = 1'b1; clr_mask = 7'h7F;
        tick(1);
        clr_wr = 1'b0; clr_mask = 7'h00;
    endtask

    task automatic t_por();
        tick(4);
        check("R1", "sys_rst in por", sys_rst, 1);
        check("R1", "status in por", status, 7'h01);
        check("R1", "irq in por", irq, 0);
        por_req = 1'b0;
        measure_width("R1");
        check("R1", "status after por", status, 7'h01);
    endtask

    task automatic t_sw();
        ctl_wr = 1'b1; ctl_wdata = 8'h5A;
        tick(1);
        ctl_wr = 1'b0;
        check("R6", "wrong key no reset", sys_rst, 0);
        tick(3);
        check("R6", "wrong key status", status, 7'h01);
        ctl_wr = 1'b1; ctl_wdata = 8'hA5;
        tick(1);
        ctl_wr = 1'b0;
        check("R6", "key status", status, 7'h08);
        measure_width("R2");
        check("R9", "status kept over reset", status, 7'h08);
    endtask

    task automatic t_xres();
        ext_rst_n = 1'b0;
        tick(3);
        ext_rst_n = 1'b1;
        tick(15);
        check("R3", "glitch no reset", sys_rst, 0);
        check("R3", "glitch status", status, 7'h08);
        ext_rst_n = 1'b0;
        tick(6);
        check("R3", "pin before due", sys_rst, 0);
        tick(1);
        check("R3", "pin reset", sys_rst, 1);
        check("R3", "pin status", status, 7'h02);
        tick(5);
        ext_rst_n = 1'b1;
        tick(30);
        check("R3", "pin released", sys_rst, 0);
    endtask

    task automatic t_wdt();
        wdt_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(14);
            wdt_kick = 1'b1;
            tick(1);
            wdt_kick = 1'b0;
            check("R5", "kicked no reset", sys_rst, 0);
        end
        tick(WDT_P);
        check("R4", "before timeout", sys_rst, 0);
        tick(1);
        check("R4", "timeout reset", sys_rst, 1);
        check("R4", "timeout status", status, 7'h04);
        wdt_en = 1'b0;
        tick(MIN_W + 2);
        wdt_en = 1'b1; sleep_mode = 1'b1;
        tick(3 * WDT_P);
        check("R5", "sleep no reset", sys_rst, 0);
        check("R5", "sleep status", status, 7'h04);
        wdt_en = 1'b0; sleep_mode = 1'b0;
        tick(2);
    endtask

    task automatic t_mon();
        clear_all();
        check("R10", "clear all", status, 7'h00);
        alo_to_rst = 1'b0;
        mon_alo = 1'b1;
        tick(1);
        check("R7", "alo irq status", status, 7'h10);
        check("R7", "alo irq", irq, 1);
        check("R7", "alo no reset", sys_rst, 0);
        mon_alo = 1'b0;
        clr_wr = 1'b1; clr_mask = 7'h40;
        tick(1);
        clr_wr = 1'b0;
        check("R10", "unmasked bit kept", status, 7'h10);
        check("R10", "irq kept", irq, 1);
        clr_wr = 1'b1; clr_mask = 7'h10;
        tick(1);
        clr_wr = 1'b0;
        check("R10", "masked bit cleared", status, 7'h00);
        check("R10", "irq dropped", irq, 0);
        alo_to_rst = 1'b1;
        mon_alo = 1'b1;
        tick(1);
        check("R7", "alo reset", sys_rst, 1);
        check("R7", "alo reset status", status, 7'h10);
        check("R7", "alo reset no irq", irq, 0);
        tick(4);
        mon_alo = 1'b0;
        measure_width("R2");
        dlo_to_rst = 1'b0;
        mon_dlo = 1'b1;
        tick(1);
        mon_dlo = 1'b0;
        check("R7", "dlo irq status", status, 7'h20);
        check("R7", "dlo irq", irq, 1);
        check("R7", "dlo no reset", sys_rst, 0);
        clear_all();
        dlo_to_rst = 1'b1;
        mon_dlo = 1'b1;
        tick(1);
        mon_dlo = 1'b0;
        check("R7", "dlo reset", sys_rst, 1);
        check("R7", "dlo reset no irq", irq, 0);
        tick(MIN_W + 2);
        mon_ahi = 1'b1;
        tick(1);
        check("R8", "ahi status", status, 7'h40);
        check("R8", "ahi irq", irq, 1);
        tick(3);
        check("R8", "ahi no reset", sys_rst, 0);
        mon_ahi = 1'b0;
        alo_to_rst = 1'b0; dlo_to_rst = 1'b0;
        clear_all();
    endtask

    task automatic t_order();
        mon_alo = 1'b1; mon_ahi = 1'b1;
        tick(1);
        mon_alo = 1'b0; mon_ahi = 1'b0;
        check("R9", "coincident lowest wins", status, 7'h10);
        check("R9", "coincident irq", irq, 1);
        mon_dlo = 1'b1;
        tick(1);
        mon_dlo = 1'b0;
        check("R9", "newer replaces", status, 7'h20);
        clear_all();
        mon_dlo = 1'b1;
        clr_wr = 1'b1; clr_mask = 7'h7F;
        tick(1);
        clr_wr = 1'b0; mon_dlo = 1'b0;
        check("R10", "event beats clear", status, 7'h20);
        check("R10", "event irq beats clear", irq, 1);
    endtask

    task automatic t_por_again();
        por_req = 1'b1;
        tick(2);
        check("R1", "por clears cause", status, 7'h01);
        check("R1", "por clears irq", irq, 0);
        por_req = 1'b0;
        tick(MIN_W + 2);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        t_por();
        t_sw();
        t_xres();
        t_wdt();
        t_mon();
        t_order();
        t_por_again();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule